// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a translation miss by fetching page table entries from memory, one level at a time. A miss arrives as a 36-bit virtual page number together with the kind of access that caused it, either data read, data write or instruction fetch, and whether the access comes from user mode. The virtual page number is cut into four 9-bit indices, and the most significant index is used first. The first table sits at the physical page given by a root base input. Every entry is 8 bytes wide. A present entry names the physical page of the next table in its bits 51..12.

While it walks, the block narrows the permissions. Write and user access survive only if every level grants them, and execute is forbidden if any level forbids it. Any entry whose reference bit is clear is written back to memory with that bit set before the walk continues. The walk ends early at the first entry that is not present. When it completes, the block checks the requested access against the narrowed permissions. It then returns one registered result: the final physical page and attributes, or a fault code.

Top module: `pgwalk_engine`

## Requirements
- R1: After reset `miss_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: The read for level L (0 first) goes to address `base*4096 + idx_L*8`. Here idx_L is `vpn[35-9L -: 9]`. The base is `root_base` at level 0 and bits 51..12 of the previous entry after that.
- R3: An entry with bit 0 clear at level L ends the walk with fault code L+1 (1..4). No further read is issued and that entry is not written back.
- R4: A present entry with bit 5 clear is rewritten at the same address with bit 5 set, before the next read or the result. A present entry with bit 5 already set causes no write.
- R5: On success, `res_writable` is the AND of bit 1 over the four entries, `res_user` is the AND of bit 2, and `res_nx` is the OR of bit 63.
- R6: On success, `res_ppn` is bits 51..12 of the last entry. `res_wthru`, `res_nocache`, `res_big` and `res_global` copy its bits 3, 4, 7 and 8.
- R7: `miss_acc` encodes 0 for read, 1 for write and 2 for fetch. After a full walk the fault code is 5 if `miss_user` is set and the user permission is missing. Otherwise it is 6 for a write without write permission, otherwise 7 for a fetch with execute forbidden, otherwise 0.
- R8: Only one miss is handled at a time. `miss_ready` stays low from the acceptance of a miss until its result, and a miss offered during that time has no effect.
- R9: A request holds its address and type while it waits for `mem_req_ready`. Every address is 8-byte aligned. No read is issued while a previous read still waits for its response.
- R10: `res_valid` is high for exactly one cycle per accepted miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | Walker is idle and takes the miss |
| miss_vpn | input | 36 | Virtual page number to translate |
| miss_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| miss_user | input | 1 | Access comes from user mode |
| root_base | input | 40 | Physical page of the first-level table |
| mem_req_valid | output | 1 | Memory request is valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for a write-back, 0 for a read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry value for a write-back |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 3 | 0 success, 1..4 level not present, 5 user, 6 write, 7 execute |
| res_ppn | output | 40 | Physical page of the translation |
| res_writable | output | 1 | Narrowed write permission |
| res_user | output | 1 | Narrowed user permission |
| res_nx | output | 1 | Narrowed execute-forbid flag |
| res_wthru | output | 1 | Write-through attribute of the last entry |
| res_nocache | output | 1 | Cache-disable attribute of the last entry |
| res_big | output | 1 | Page-size bit of the last entry |
| res_global | output | 1 | Global bit of the last entry |

## Verification
The bench runs several hundred walks whose entries carry pseudo-random attribute bits, with random memory stalls and response delays. The index extremes, all zeros and all ones, are included. A missing entry is placed at each of the four levels in turn. If the walker stopped at the wrong level, or wrote back a non-present entry, the read log and the write count would show it. If it combined permissions with the wrong operator, `res_writable` or `res_nx` would differ on walks that mix granting and denying levels. If it skipped the reference write or wrote it at the wrong time, the memory image after the walk would still have bit 5 clear, or the write count would be wrong. A second miss is held on the input for the whole walk, so a walker that leaks acceptance would issue extra reads.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // walk sequencer states
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WB_REQ  = 2'd3
  } walk_state_e;

  // access kinds carried with a miss
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  // entry bit positions that hardware interprets
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;
  localparam int unsigned BIT_WTHRU   = 3;
  localparam int unsigned BIT_NOCACHE = 4;
  localparam int unsigned BIT_REF     = 5;
  localparam int unsigned BIT_BIG     = 7;
  localparam int unsigned BIT_GLOBAL  = 8;

  // narrowed permissions accumulated over the levels
  typedef struct packed {
    logic wr;
    logic usr;
    logic nx;
  } perm_t;

  localparam perm_t PERM_OPEN = '{wr: 1'b1, usr: 1'b1, nx: 1'b0};

  // pass-through attributes of the final entry
  typedef struct packed {
    logic wthru;
    logic nocache;
    logic big;
    logic global_pg;
  } attr_t;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 40,
  parameter int OFF_W  = 12,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  input  logic [PPN_W-1:0] base,
  output logic [PA_W-1:0]  addr
);

  logic [IDX_W-1:0] idx_arr [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  // level 0 takes the most significant slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_arr[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx_sel = idx_arr[i];
    end
  end

  // entries are 8 bytes: index scaled by 8 inside the page
  assign addr = {base, {OFF_W{1'b0}}} + PA_W'({idx_sel, 3'b000});

endmodule

// File: rtl/pgwalk_pte.sv
module pgwalk_pte
  import pgwalk_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int PPN_W = 40,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0] pte,
  input  perm_t            perm_in,
  output logic             present,
  output logic             ref_set,
  output logic [PPN_W-1:0] next_base,
  output perm_t            perm_out,
  output attr_t            attr,
  output logic [PTE_W-1:0] wb_data
);

  assign present   = pte[BIT_PRESENT];
  assign ref_set   = pte[BIT_REF];
  assign next_base = pte[OFF_W +: PPN_W];

  // AND/OR narrowing is idempotent, so re-applying the same entry is harmless
  assign perm_out.wr  = perm_in.wr  & pte[BIT_WRITE];
  assign perm_out.usr = perm_in.usr & pte[BIT_USER];
  assign perm_out.nx  = perm_in.nx  | pte[PTE_W-1];

  assign attr.wthru     = pte[BIT_WTHRU];
  assign attr.nocache   = pte[BIT_NOCACHE];
  assign attr.big       = pte[BIT_BIG];
  assign attr.global_pg = pte[BIT_GLOBAL];

  assign wb_data = pte | (PTE_W'(1) << BIT_REF);

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 40,
  parameter int PTE_W  = 64,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int FC_W  = $clog2(LEVELS + 4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic [1:0]       miss_acc,
  input  logic             miss_user,
  input  logic [PPN_W-1:0] root_base,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  input  logic             rsp_valid,
  input  logic [PTE_W-1:0] rsp_data,
  // datapath hooks
  output logic [VPN_W-1:0] vpn_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [PPN_W-1:0] base_q,
  output logic [PTE_W-1:0] dec_entry,
  output perm_t            perm_q,
  input  logic             dec_present,
  input  logic             dec_ref,
  input  logic [PPN_W-1:0] dec_next,
  input  perm_t            dec_perm,
  input  attr_t            dec_attr,
  // result
  output logic             res_valid,
  output logic [FC_W-1:0]  res_fault,
  output logic [PPN_W-1:0] res_ppn,
  output perm_t            res_perm,
  output attr_t            res_attr
);

  walk_state_e      state_q;
  logic [PTE_W-1:0] entry_q;
  logic [1:0]       acc_q;
  logic             user_q;
  logic             do_adv;
  logic             last_lvl;
  logic [FC_W-1:0]  perm_code;

  assign miss_ready = (state_q == ST_IDLE);
  assign req_valid  = (state_q == ST_RD_REQ) || (state_q == ST_WB_REQ);
  assign req_write  = (state_q == ST_WB_REQ);

  // decoder looks at fresh read data while waiting, otherwise the held entry
  assign dec_entry = (state_q == ST_RD_WAIT) ? rsp_data : entry_q;

  assign last_lvl = (lvl_q == LVL_W'(LEVELS - 1));

  assign do_adv = ((state_q == ST_RD_WAIT) && rsp_valid && dec_present && dec_ref) ||
                  ((state_q == ST_WB_REQ) && req_ready);

  // permission verdict on the fully narrowed set, user first then write then fetch
  always_comb begin
    if (user_q && !dec_perm.usr)                  perm_code = FC_W'(LEVELS + 1);
    else if (acc_q == ACC_WRITE && !dec_perm.wr)  perm_code = FC_W'(LEVELS + 2);
    else if (acc_q == ACC_FETCH && dec_perm.nx)   perm_code = FC_W'(LEVELS + 3);
    else                                          perm_code = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      entry_q   <= '0;
      vpn_q     <= '0;
      lvl_q     <= '0;
      base_q    <= '0;
      acc_q     <= ACC_READ;
      user_q    <= 1'b0;
      perm_q    <= PERM_OPEN;
      res_valid <= 1'b0;
      res_fault <= '0;
      res_ppn   <= '0;
      res_perm  <= PERM_OPEN;
      res_attr  <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (miss_valid) begin
            vpn_q   <= miss_vpn;
            acc_q   <= miss_acc;
            user_q  <= miss_user;
            base_q  <= root_base;
            lvl_q   <= '0;
            perm_q  <= PERM_OPEN;
            state_q <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (req_ready) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rsp_valid) begin
            entry_q <= rsp_data;
            perm_q  <= dec_perm;
            if (!dec_present) begin
              res_valid <= 1'b1;
              res_fault <= FC_W'(lvl_q) + FC_W'(1);
              state_q   <= ST_IDLE;
            end else if (!dec_ref) begin
              state_q <= ST_WB_REQ;
            end
          end
        end
        ST_WB_REQ: ;
        default: state_q <= ST_IDLE;
      endcase

      if (do_adv) begin
        if (last_lvl) begin
          res_valid <= 1'b1;
          res_fault <= perm_code;
          res_ppn   <= dec_next;
          res_perm  <= dec_perm;
          res_attr  <= dec_attr;
          state_q   <= ST_IDLE;
        end else begin
          base_q  <= dec_next;
          lvl_q   <= lvl_q + 1'b1;
          state_q <= ST_RD_REQ;
        end
      end
    end
  end

endmodule

// File: rtl/pgwalk_engine.sv
module pgwalk_engine
  import pgwalk_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 40,
  parameter int OFF_W  = 12,
  parameter int PTE_W  = 64,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int FC_W  = $clog2(LEVELS + 4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic [1:0]       miss_acc,
  input  logic             miss_user,
  input  logic [PPN_W-1:0] root_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic [FC_W-1:0]  res_fault,
  output logic [PPN_W-1:0] res_ppn,
  output logic             res_writable,
  output logic             res_user,
  output logic             res_nx,
  output logic             res_wthru,
  output logic             res_nocache,
  output logic             res_big,
  output logic             res_global
);

  logic [VPN_W-1:0] vpn_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] base_q;
  logic [PTE_W-1:0] dec_entry;
  perm_t            perm_q;
  logic             dec_present;
  logic             dec_ref;
  logic [PPN_W-1:0] dec_next;
  perm_t            dec_perm;
  attr_t            dec_attr;
  perm_t            res_perm;
  attr_t            res_attr;

  pgwalk_ctrl #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .PTE_W(PTE_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vpn(miss_vpn),
    .miss_acc(miss_acc), .miss_user(miss_user), .root_base(root_base),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_write(mem_req_write),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .vpn_q(vpn_q), .lvl_q(lvl_q), .base_q(base_q), .dec_entry(dec_entry), .perm_q(perm_q),
    .dec_present(dec_present), .dec_ref(dec_ref), .dec_next(dec_next),
    .dec_perm(dec_perm), .dec_attr(dec_attr),
    .res_valid(res_valid), .res_fault(res_fault), .res_ppn(res_ppn),
    .res_perm(res_perm), .res_attr(res_attr)
  );

  pgwalk_addr #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
  ) addr_i (
    .vpn(vpn_q), .level(lvl_q), .base(base_q), .addr(mem_req_addr)
  );

  pgwalk_pte #(
    .PTE_W(PTE_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
  ) pte_i (
    .pte(dec_entry), .perm_in(perm_q), .present(dec_present), .ref_set(dec_ref),
    .next_base(dec_next), .perm_out(dec_perm), .attr(dec_attr), .wb_data(mem_req_wdata)
  );

  assign res_writable = res_perm.wr;
  assign res_user     = res_perm.usr;
  assign res_nx       = res_perm.nx;
  assign res_wthru    = res_attr.wthru;
  assign res_nocache  = res_attr.nocache;
  assign res_big      = res_attr.big;
  assign res_global   = res_attr.global_pg;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int PA_W  = 52,
  parameter int PTE_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [PTE_W-1:0] mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic             res_valid
);

  logic rd_open_q;

  always_ff @(posedge clk) begin
    if (rst) rd_open_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_open_q <= 1'b1;
    else if (mem_rsp_valid) rd_open_q <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R9

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R9

  AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_write) |-> !rd_open_q); // R9

  AST_WB_REF_SET: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]); // R4

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> !miss_ready); // R8

  AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R10

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    miss_ready |-> !mem_req_valid); // R8

endmodule

bind pgwalk_engine pgwalk_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) chk_i (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .res_valid(res_valid)
);

// File: tb/pgwalk_engine_tb_top.sv
`timescale 1ns/1ps
module pgwalk_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [35:0] miss_vpn = '0;
  logic [1:0]  miss_acc = '0;
  logic        miss_user = 1'b0;
  logic [39:0] root_base = 40'd1;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [2:0]  res_fault;
  logic [39:0] res_ppn;
  logic        res_writable, res_user, res_nx, res_wthru, res_nocache, res_big, res_global;

  always #2 clk = ~clk;

  pgwalk_engine dut_i (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_vpn(miss_vpn), .miss_acc(miss_acc), .miss_user(miss_user), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_ppn(res_ppn),
    .res_writable(res_writable), .res_user(res_user), .res_nx(res_nx),
    .res_wthru(res_wthru), .res_nocache(res_nocache), .res_big(res_big), .res_global(res_global)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // ---------------- memory model ----------------
  logic [63:0] mem [0:4095];
  logic [51:0] rd_log [0:7];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          overlap = 0;
  int          pend = 0;
  logic [11:0] pend_idx = '0;
  logic [31:0] mlfsr = 32'h1234_5679;

  always @(posedge clk) begin
    mlfsr <= {mlfsr[30:0], mlfsr[31] ^ mlfsr[21] ^ mlfsr[1] ^ mlfsr[0]};
    mem_req_ready <= (mlfsr[2:0] != 3'd0);
    mem_rsp_valid <= 1'b0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[pend_idx];
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[14:3]] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        if (pend != 0 || mem_rsp_valid) overlap <= overlap + 1;
        rd_log[rd_cnt[2:0]] <= mem_req_addr;
        rd_cnt <= rd_cnt + 1;
        pend_idx <= mem_req_addr[14:3];
        pend <= 1 + int'(mlfsr[4:3] % 2'd3);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  logic [31:0] seed = 32'hC0FF_EE01;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      summary();
      $finish;
    end
  end

  // one walk: entries e[0..3] at pages 1..4, vpn indices idx
  task automatic walk(input logic [63:0] e [4], input logic [8:0] idx [4],
                      input logic [1:0] acc, input bit usr);
    logic [35:0] vpn;
    int          rd0, wr0, ov0, stop_lvl, exp_wr, k;
    bit          busy_ok;
    logic [2:0]  exp_code;
    bit          w, u, x;
    vpn = {idx[0], idx[1], idx[2], idx[3]};
    for (int l = 0; l < 4; l++) mem[(l + 1) * 512 + int'(idx[l])] = e[l];
    stop_lvl = 4;
    for (int l = 3; l >= 0; l--) if (!e[l][0]) stop_lvl = l;
    exp_wr = 0;
    w = 1; u = 1; x = 0;
    for (int l = 0; l < 4; l++) begin
      if (l < stop_lvl) begin
        if (!e[l][5]) exp_wr++;
        w &= e[l][1]; u &= e[l][2]; x |= e[l][63];
      end
    end
    if (stop_lvl < 4)               exp_code = 3'(stop_lvl + 1);
    else if (usr && !u)             exp_code = 3'd5;
    else if (acc == 2'd1 && !w)     exp_code = 3'd6;
    else if (acc == 2'd2 && x)      exp_code = 3'd7;
    else                            exp_code = 3'd0;

    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt; ov0 = overlap;
    miss_vpn = vpn; miss_acc = acc; miss_user = usr; miss_valid = 1'b1;
    @(negedge clk);
    // keep offering an unrelated miss for the whole walk (R8)
    miss_vpn = ~vpn; miss_acc = 2'd0; miss_user = 1'b0;
    busy_ok = 1; k = 0;
    while (!res_valid && k < 200) begin
      if (miss_ready) busy_ok = 0;
      @(negedge clk);
      k++;
    end
    miss_valid = 1'b0;
    chk(busy_ok, "R8 busy", 64'(miss_ready), 64'd0);
    chk(res_fault == exp_code, (stop_lvl < 4) ? "R3 fault code" : "R7 fault code",
        64'(res_fault), 64'(exp_code));
    if (exp_code == 3'd0) begin
      chk({res_writable, res_user, res_nx} == {w, u, x}, "R5 perms",
          64'({res_writable, res_user, res_nx}), 64'({w, u, x}));
      chk({res_ppn, res_wthru, res_nocache, res_big, res_global} ==
          {e[3][51:12], e[3][3], e[3][4], e[3][7], e[3][8]}, "R6 final fields",
          64'({res_ppn, res_wthru, res_nocache, res_big, res_global}),
          64'({e[3][51:12], e[3][3], e[3][4], e[3][7], e[3][8]}));
    end
    chk(rd_cnt - rd0 == ((stop_lvl < 4) ? stop_lvl + 1 : 4), "R3 read count",
        64'(rd_cnt - rd0), 64'((stop_lvl < 4) ? stop_lvl + 1 : 4));
    for (int l = 0; l < 4; l++) begin
      if (l < rd_cnt - rd0) begin
        logic [51:0] ea;
        ea = 52'((l + 1) * 4096 + int'(idx[l]) * 8);
        chk(rd_log[(rd0 + l) % 8] == ea, "R2 read address", 64'(rd_log[(rd0 + l) % 8]), 64'(ea));
      end
    end
    chk(wr_cnt - wr0 == exp_wr, "R4 write-back count", 64'(wr_cnt - wr0), 64'(exp_wr));
    for (int l = 0; l < 4; l++) begin
      logic [63:0] ex;
      ex = (l < stop_lvl) ? (e[l] | 64'h20) : e[l];
      chk(mem[(l + 1) * 512 + int'(idx[l])] == ex, "R4 memory image",
          mem[(l + 1) * 512 + int'(idx[l])], ex);
    end
    chk(overlap == ov0, "R9 single read", 64'(overlap - ov0), 64'd0);
    @(negedge clk);
    chk(!res_valid, "R10 strobe width", 64'(res_valid), 64'd0);
  endtask

  initial begin
    logic [63:0] e [4];
    logic [8:0]  idx [4];
    logic [1:0]  acc;
    bit          usr;
    int          miss_lvl;
    repeat (3) @(negedge clk);
    chk(miss_ready && !mem_req_valid && !res_valid, "R1 reset state",
        64'({miss_ready, mem_req_valid, res_valid}), 64'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(miss_ready && !mem_req_valid && !res_valid, "R1 after release",
        64'({miss_ready, mem_req_valid, res_valid}), 64'b100);

    for (int t = 0; t < 400; t++) begin
      miss_lvl = (t % 8 == 7) ? (t / 8) % 4 : 4;
      for (int l = 0; l < 4; l++) begin
        seed = nxt(seed);
        idx[l] = (t == 0) ? 9'd0 : (t == 1) ? 9'h1FF : seed[8:0];
        seed = nxt(seed);
        e[l] = '0;
        e[l][0]  = (l != miss_lvl);
        e[l][1]  = (seed[2:0] != 3'd0) || (t < 8);
        e[l][2]  = (seed[5:3] != 3'd0) || (t < 8);
        e[l][3]  = seed[6];
        e[l][4]  = seed[7];
        e[l][5]  = seed[8];
        e[l][7]  = seed[9];
        e[l][8]  = seed[10];
        e[l][63] = (seed[13:11] == 3'd0) && (t >= 8);
        if (l < 3) e[l][51:12] = 40'(l + 2);
        else       e[l][51:12] = (t == 2) ? 40'hFF_FFFF_FFFF : {seed[31:14], 22'h2A5A5};
        if (l == miss_lvl) e[l][62:9] = {seed, seed[21:0]};
      end
      seed = nxt(seed);
      acc = 2'(seed[1:0] % 2'd3);
      usr = seed[2];
      walk(e, idx, acc, usr);
    end
    done = 1;
    summary();
    $finish;
  end

endmodule